// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement integers of parameterised width `N` over several clock cycles, one multiplier bit per cycle. A one-cycle `start` pulse captures both operands. The multiplicand stays in a holding register. The multiplier sits in a shift register, with an extra flip-flop to its right that keeps the bit most recently shifted out. In each step the pair formed by the multiplier's low bit and that extra bit selects one of three actions on the accumulator: add the multiplicand, subtract it, or leave the accumulator alone. Accumulator, multiplier register and extra bit then move one place to the right together as an arithmetic shift.

After `N` steps the accumulator and multiplier register, joined, hold the full `2N`-bit signed product. `done` rises for one cycle at that point. The product stays on its port until the next operation is accepted.

The controller has three named states. `ST_IDLE` waits and moves to `ST_STEP` when `start` is seen (the *accept* transition, which loads the operands). `ST_STEP` runs one Booth step per cycle while its step counter counts down from `N`. When the last step retires it takes the *finish* transition to `ST_DONE`. `ST_DONE` lasts exactly one cycle and returns to `ST_IDLE` unconditionally (the *release* transition).

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is held and right after it is released, `done` is 0 and `product` is all zeros.
- R2: `start` is accepted only in `ST_IDLE`. The rising edge that accepts it loads both operands, clears the accumulator and the extra bit, and sets the step counter to `N`. `done` is then high in the cycle that follows the `N`-th rising edge after the accepting edge.
- R3: `done` is high for exactly one cycle per operation, and `product` holds its value from that cycle until the next accepted `start`.
- R4: `start` has no effect while an operation is running or in the `ST_DONE` cycle: the running operation's result and its `done` timing are unchanged.
- R5: Each step decodes the pair {multiplier low bit, extra bit}. Pair 1,0 subtracts the multiplicand from the accumulator, pair 0,1 adds it, and an equal pair leaves the accumulator unchanged. After that the whole word shifts right by one with the accumulator's sign bit replicated.
- R6: `product` equals the exact signed product of the two operands for positive, negative and zero operands of either sign.
- R7: The result is exact at the range corners, including most-negative times most-negative, which gives 2^(2N-2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new multiplication (used only when idle) |
| mcand | input | N | Signed multiplicand, sampled on the accepting edge |
| mplier | input | N | Signed multiplier, sampled on the accepting edge |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2N | Signed product {accumulator low N bits, multiplier register} |

## Verification
The assertions assume that `start` is driven to a defined level on every clock and that the operands are stable around the edge that accepts them. Nothing is assumed about the operand values, since every bit pattern is a legal two's-complement number. The stimulus changes `start` and the operands only on falling edges, and it deliberately raises `start` in the middle of a run and during the `done` cycle. This drives the controller through every state and transition, including the ignored-request paths.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_t;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_SUB  = 2'd2
    } step_act_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      q_lsb,
    input  logic      q_prev,
    output step_act_t act
);

    always_comb begin
        unique case ({q_lsb, q_prev})
            2'b10:   act = ACT_SUB;
            2'b01:   act = ACT_ADD;
            default: act = ACT_KEEP;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] opnd,
    input  step_act_t    act,
    output logic [W-1:0] res
);

    logic [W-1:0] opnd_sel;
    logic         cin;

    always_comb begin
        unique case (act)
            ACT_ADD: begin
                opnd_sel = opnd;
                cin      = 1'b0;
            end
            ACT_SUB: begin
                opnd_sel = ~opnd;
                cin      = 1'b1;
            end
            default: begin
                opnd_sel = '0;
                cin      = 1'b0;
            end
        endcase
        res = acc + opnd_sel + {{(W-1){1'b0}}, cin};
    end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic done
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(N);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    ctrl_state_t    state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        step    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    cnt_d   = CNT_INIT;
                    state_d = ST_STEP;
                end
            end
            ST_STEP: begin
                step  = 1'b1;
                cnt_d = cnt_q - CNT_ONE;
                if (cnt_q == CNT_ONE) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R3: done lasts a single cycle
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R2: counter stays within 1..N while stepping
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> (cnt_q != '0 && cnt_q <= CNT_INIT));

    // R2: each step cycle removes exactly one from the counter
    p_cnt_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && cnt_q != CNT_ONE) |=>
            (state_q == ST_STEP && cnt_q == $past(cnt_q) - CNT_ONE));

    // R4: start is not taken in the done cycle
    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && start) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           done,
    output logic [2*N-1:0] product
);

    localparam int AW = N + 1;

    logic [N-1:0]  br_q;
    logic [AW-1:0] ac_q;
    logic [N-1:0]  qr_q;
    logic          qm1_q;

    logic          load, step;
    step_act_t     act;
    logic [AW-1:0] ac_next;
    logic [AW-1:0] br_ext;

    assign br_ext = {br_q[N-1], br_q};

    booth_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .done  (done)
    );

    booth_recode u_recode (
        .q_lsb  (qr_q[0]),
        .q_prev (qm1_q),
        .act    (act)
    );

    booth_addsub #(.W(AW)) u_addsub (
        .acc  (ac_q),
        .opnd (br_ext),
        .act  (act),
        .res  (ac_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br_q  <= '0;
            ac_q  <= '0;
            qr_q  <= '0;
            qm1_q <= 1'b0;
        end else if (load) begin
            br_q  <= mcand;
            ac_q  <= '0;
            qr_q  <= mplier;
            qm1_q <= 1'b0;
        end else if (step) begin
            {ac_q, qr_q, qm1_q} <= {ac_next[AW-1], ac_next, qr_q};
        end
    end

    assign product = {ac_q[N-1:0], qr_q};

    // R2: the accepting edge clears accumulator and extra bit
    p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ac_q == '0 && qm1_q == 1'b0));

    // R5: an equal pair only shifts the accumulator arithmetically
    p_skip_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (qr_q[0] == qm1_q)) |=>
            (ac_q == {$past(ac_q[AW-1]), $past(ac_q[AW-1:1])}));

    // R4: the multiplicand is not reloaded while not idle
    p_br_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step || done) |=> $stable(br_q));

    // R7: the guard bit always agrees with the n-bit sign after a step
    p_guard_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ac_q[AW-1] == ac_q[AW-2]));

    // R3: product is unchanged in the cycle after done
    p_prod_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(product));

endmodule

// File: tb/sim_booth_seq_mult.sv
`timescale 1ns/1ps
module sim_booth_seq_mult;

    localparam int N = 8;
    localparam int NV = 13;

    // each entry: {multiplicand, multiplier}
    localparam logic [2*N-1:0] VEC [NV] = '{
        16'h0305, 16'hFD05, 16'h07FF, 16'h8001, 16'h0180,
        16'h00B3, 16'hFFFF, 16'h7F7F, 16'h807F, 16'h7F80,
        16'h55AA, 16'h0E0E, 16'hC355
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           done;
    logic [2*N-1:0] product;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    booth_seq_mult #(.N(N)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .done    (done),
        .product (product)
    );

    task automatic check(input string req, input logic [2*N-1:0] act,
                         input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a,
                                               input logic [N-1:0] b);
        logic signed [N-1:0]   sa;
        logic signed [N-1:0]   sb;
        logic signed [2*N-1:0] e;
        sa = a;
        sb = b;
        e  = sa * sb;
        return e;
    endfunction

    // Runs one operation. mid_start raises start with junk operands at
    // cycle 3 of the run; late_start holds start high during done.
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                          input bit mid_start, input bit late_start,
                          input string req);
        int waited;
        logic [2*N-1:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        waited = 0;
        while (done !== 1'b1 && waited < 4*N) begin
            @(negedge clk);
            waited++;
            if (mid_start && waited == 3) begin
                start  = 1'b1;
                mcand  = ~a;
                mplier = ~b;
            end else if (mid_start && waited == 4) begin
                start  = 1'b0;
            end
            if (late_start && waited == N - 1) start = 1'b1;
        end
        // R2: done appears N edges after the accepting edge
        check({req, " R2 latency"}, 16'(waited), 16'(N));
        check({req, " R6 product"}, product, exp);
        @(negedge clk);
        start = 1'b0;
        // R3: one-cycle pulse, product held
        check({req, " R3 done low"}, 16'(done), 16'd0);
        check({req, " R3 held"}, product, exp);
        if (late_start) begin
            repeat (3) @(negedge clk);
            // R4: start in done cycle started nothing
            check({req, " R4 no restart"}, 16'(done), 16'd0);
            check({req, " R4 product kept"}, product, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done in reset", 16'(done), 16'd0);
        check("R1 product in reset", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", 16'(done), 16'd0);
        check("R1 product after reset", product, '0);

        // R5 and R6: table of operand pairs
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][2*N-1:N], VEC[i][N-1:0], 1'b0, 1'b0, "R5 table");
        end

        // R7: corners
        run_op(8'h80, 8'h80, 1'b0, 1'b0, "R7 minmin");
        check("R7 minmin literal", product, 16'h4000);
        run_op(8'h80, 8'hFF, 1'b0, 1'b0, "R7 min*-1");
        run_op(8'hFF, 8'h80, 1'b0, 1'b0, "R7 -1*min");

        // R4: start mid-run and in the done cycle
        run_op(8'h93, 8'h2D, 1'b1, 1'b0, "R4 mid");
        run_op(8'h6B, 8'hC7, 1'b0, 1'b1, "R4 late");

        // R2: back-to-back after a finished op
        run_op(8'h00, 8'h00, 1'b0, 1'b0, "R2 zero");
        run_op(8'hA5, 8'h01, 1'b0, 1'b0, "R2 next");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule